// File: doc/BRIEF.md
# EEE Low-Power-Idle Status and Interrupt Controller

This block follows the low-power-idle (LPI) state of both directions of an Ethernet MAC and exposes it to a host through one control/status word. The transmit side enters LPI when the host sets an enable bit. The receive side enters LPI when the PHY starts sending the LPI pattern, and leaves it when the PHY reports LPI exit. Both receive indications come from the receive clock domain. Each is passed through a synchronizer and a rising-edge detector before it acts in the register clock domain.

Three sticky event bits record TX entry, RX entry and RX exit. The two entry bits drive a main interrupt line. The exit bit drives a separate exit interrupt line. Any host read returns the word and clears the event bits. The block also drives a qualifier that tells the clock-control logic when it is safe to stop the register clock. That is only the case while both directions sit in LPI, because otherwise events from the active side would go unrecorded.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: While reset is held, and after it is released, `reg_rdata_o` is 0 and `irq_o`, `exit_irq_o` and `clk_gate_ok_o` are low.
- R2: A write with bit 16 = 1 while TX is out of LPI puts TX in LPI and sets TX-entry bit 0 after that edge. Bit 16 reads back as the TX LPI state. A further such write while TX is already in LPI leaves bit 0 clear.
- R3: A write with bit 16 = 0 takes TX out of LPI. Every other written bit has no effect, so the event bits cannot be set or cleared by a write.
- R4: A rise of `rx_lpi_pattern_i` sets RX LPI state (bit 8) and RX-entry bit 1 on the third rising clock edge after the change, because of the two-flop synchronizer and the edge detector. Holding the pattern high does not set bit 1 again.
- R5: A rise of `rx_lpi_exit_i` clears bit 8 and sets RX-exit bit 2, with the same synchronization latency.
- R6: `irq_o` is high exactly while bit 0 or bit 1 is set. `exit_irq_o` is high exactly while bit 2 is set.
- R7: A read returns the current word in the cycle `reg_rd_i` is high, and clears bits 0 to 2 at the end of that cycle.
- R8: An event that arrives in the same cycle as a read wins, so its bit stays set after the read.
- R9: `clk_gate_ok_o`, mirrored in bit 9, is high only while both TX and RX are in LPI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_lpi_pattern_i | input | 1 | Level from the receive domain: PHY is sending the LPI pattern |
| rx_lpi_exit_i | input | 1 | Level from the receive domain: PHY has left LPI |
| reg_wr_i | input | 1 | Host write strobe |
| reg_rd_i | input | 1 | Host read strobe (clear-on-read) |
| reg_wdata_i | input | DATA_W | Host write data; only bit 16 is used |
| reg_rdata_o | output | DATA_W | Control/status word |
| irq_o | output | 1 | Main interrupt: TX or RX LPI entry pending |
| exit_irq_o | output | 1 | LPI-exit interrupt |
| clk_gate_ok_o | output | 1 | Register clock may be stopped |

## Verification
The controller is driven through TX-only LPI, RX-only LPI and both together. This shows that the gate qualifier follows the AND of the two states rather than either one alone. Repeated enable writes and a held LPI pattern separate edge-triggered entry status from level-triggered status. Writes carrying ones in the event positions show that writes cannot touch the event bits. A write that raises TX entry in the same cycle as a clearing read shows that a new event wins over the clear. A simultaneous pattern drop and exit indication checks that the exit path goes only to the separate interrupt line.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;
  // event bit positions in the status word
  localparam int EVT_TX_ENT  = 0;
  localparam int EVT_RX_ENT  = 1;
  localparam int EVT_RX_EXIT = 2;
  localparam int NUM_EVT     = 3;
  // state bit positions
  localparam int RX_STATE_BIT = 8;
  localparam int GATE_BIT     = 9;
  localparam int TX_EN_BIT    = 16;

  typedef struct packed {
    logic tx;
    logic rx;
  } lpi_state_t;
endpackage

// File: rtl/eee_lpi_rst_sync.sv
module eee_lpi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/eee_lpi_sync_edge.sv
module eee_lpi_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R4
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/eee_lpi_tx_track.sv
module eee_lpi_tx_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic en_bit_i,
  output logic tx_lpi_o,
  output logic entry_set_o
);
  logic tx_q;
  logic tx_d;
  logic tx_ce;

  always_comb begin
    tx_ce       = wr_i;
    tx_d        = en_bit_i;
    entry_set_o = wr_i & en_bit_i & ~tx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= 1'b0;
    end else if (tx_ce) begin
      tx_q <= tx_d;
    end
  end

  assign tx_lpi_o = tx_q;

  // R3
  tx_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !en_bit_i) |=> !tx_lpi_o);
  // R2
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(tx_lpi_o));
endmodule

// File: rtl/eee_lpi_rx_track.sv
module eee_lpi_rx_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pat_rise_i,
  input  logic exit_rise_i,
  output logic rx_lpi_o,
  output logic entry_set_o,
  output logic exit_set_o
);
  logic rx_q;
  logic rx_d;
  logic rx_ce;

  always_comb begin
    entry_set_o = pat_rise_i & ~rx_q & ~exit_rise_i;
    exit_set_o  = exit_rise_i;
    rx_ce       = entry_set_o | exit_rise_i;
    rx_d        = ~exit_rise_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= 1'b0;
    end else if (rx_ce) begin
      rx_q <= rx_d;
    end
  end

  assign rx_lpi_o = rx_q;

  // R5
  rx_exit_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_rise_i |=> !rx_lpi_o);
  // R4
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_lpi_o && !exit_rise_i) |=> rx_lpi_o);
endmodule

// File: rtl/eee_lpi_sticky.sv
module eee_lpi_sticky #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_q;
  logic [N-1:0] q_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      q_d[i] = set_i[i] | (q_q[i] & ~clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_q[i] <= 1'b0;
      end else begin
        q_q[i] <= q_d[i];
      end
    end

    // R8
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_o[i]);
    // R7
    rd_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i[i]) |=> !q_o[i]);
    // R3
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !set_i[i]) |=> $stable(q_o[i]));
  end

  assign q_o = q_q;
endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
  import eee_lpi_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_lpi_pattern_i,
  input  logic              rx_lpi_exit_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              exit_irq_o,
  output logic              clk_gate_ok_o
);
  logic               rst_n;
  logic               pat_rise;
  logic               exit_rise;
  logic               tx_entry_set;
  logic               rx_entry_set;
  logic               rx_exit_set;
  logic [NUM_EVT-1:0] evt_set;
  logic [NUM_EVT-1:0] evt_q;
  lpi_state_t         state;
  logic               unused_wdata;

  eee_lpi_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  eee_lpi_sync_edge #(.STAGES(SYNC_STAGES)) u_pat_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .async_i (rx_lpi_pattern_i),
    .rise_o  (pat_rise)
  );

  eee_lpi_sync_edge #(.STAGES(SYNC_STAGES)) u_exit_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .async_i (rx_lpi_exit_i),
    .rise_o  (exit_rise)
  );

  eee_lpi_tx_track u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .wr_i        (reg_wr_i),
    .en_bit_i    (reg_wdata_i[TX_EN_BIT]),
    .tx_lpi_o    (state.tx),
    .entry_set_o (tx_entry_set)
  );

  eee_lpi_rx_track u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .pat_rise_i  (pat_rise),
    .exit_rise_i (exit_rise),
    .rx_lpi_o    (state.rx),
    .entry_set_o (rx_entry_set),
    .exit_set_o  (rx_exit_set)
  );

  always_comb begin
    evt_set              = '0;
    evt_set[EVT_TX_ENT]  = tx_entry_set;
    evt_set[EVT_RX_ENT]  = rx_entry_set;
    evt_set[EVT_RX_EXIT] = rx_exit_set;
  end

  eee_lpi_sticky #(.N(NUM_EVT)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .set_i  (evt_set),
    .clr_i  (reg_rd_i),
    .q_o    (evt_q)
  );

  always_comb begin
    clk_gate_ok_o = state.tx & state.rx;
    irq_o         = evt_q[EVT_TX_ENT] | evt_q[EVT_RX_ENT];
    exit_irq_o    = evt_q[EVT_RX_EXIT];
    reg_rdata_o                = '0;
    reg_rdata_o[NUM_EVT-1:0]   = evt_q;
    reg_rdata_o[RX_STATE_BIT]  = state.rx;
    reg_rdata_o[GATE_BIT]      = clk_gate_ok_o;
    reg_rdata_o[TX_EN_BIT]     = state.tx;
  end

  assign unused_wdata = ^reg_wdata_i;

  // R2
  tx_entry_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(state.tx) |-> evt_q[EVT_TX_ENT]);
  // R4
  rx_entry_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(state.rx) |-> evt_q[EVT_RX_ENT]);
  // R5
  rx_exit_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(state.rx) |-> evt_q[EVT_RX_EXIT]);
endmodule

// File: tb/eee_lpi_ctrl_tb_top.sv
module eee_lpi_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pat, ext, wr, rd;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq, exit_irq, gate_ok;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        mon_ev;

  always #5 clk = ~clk;

  eee_lpi_ctrl dut_i (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .rx_lpi_pattern_i (pat),
    .rx_lpi_exit_i    (ext),
    .reg_wr_i         (wr),
    .reg_rd_i         (rd),
    .reg_wdata_i      (wdata),
    .reg_rdata_o      (rdata),
    .irq_o            (irq),
    .exit_irq_o       (exit_irq),
    .clk_gate_ok_o    (gate_ok)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data and compares while the read strobe is high
  always @(mon_ev) begin
    logic [31:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    chk(t, rdata, e);
  end

  task automatic rd_exp(input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd = 1'b1;
    #1 -> mon_ev;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr_word(input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1;
    wdata = d;
    @(negedge clk);
    wr = 1'b0;
    wdata = '0;
  endtask

  task automatic wr_rd(input logic [31:0] d, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    wr = 1'b1;
    rd = 1'b1;
    wdata = d;
    #1 -> mon_ev;
    @(negedge clk);
    wr = 1'b0;
    rd = 1'b0;
    wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; pat = 1'b0; ext = 1'b0; wr = 1'b0; rd = 1'b0; wdata = '0;
    idle(3);
    chk("R1 rdata in reset", rdata, 32'h0);
    chk("R1 outputs in reset", {29'd0, irq, exit_irq, gate_ok}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    chk("R1 rdata after reset", rdata, 32'h0);

    // TX entry
    wr_word(32'h0001_0000);
    chk("R6 irq on tx entry", {31'd0, irq}, 32'h1);
    chk("R9 gate low tx only", {31'd0, gate_ok}, 32'h0);
    rd_exp(32'h0001_0001, "R2 tx entry status");
    chk("R7 irq cleared by read", {31'd0, irq}, 32'h0);
    rd_exp(32'h0001_0000, "R7 status cleared");
    wr_word(32'h0001_0000);
    rd_exp(32'h0001_0000, "R2 no re-entry while in tx lpi");

    // RX entry
    @(negedge clk); pat = 1'b1;
    idle(5);
    chk("R9 gate high both in lpi", {31'd0, gate_ok}, 32'h1);
    chk("R6 irq on rx entry", {31'd0, irq}, 32'h1);
    rd_exp(32'h0001_0302, "R4 rx entry status");
    idle(6);
    rd_exp(32'h0001_0300, "R4 no re-entry while pattern held");
    wr_word(32'h0001_0007);
    rd_exp(32'h0001_0300, "R3 event bits ignore writes");

    // TX exit
    wr_word(32'h0000_0000);
    chk("R9 gate low rx only", {31'd0, gate_ok}, 32'h0);
    rd_exp(32'h0000_0100, "R3 tx exit");

    // RX exit
    @(negedge clk); pat = 1'b0; ext = 1'b1;
    idle(5);
    chk("R6 exit irq set", {31'd0, exit_irq}, 32'h1);
    chk("R6 main irq quiet on exit", {31'd0, irq}, 32'h0);
    rd_exp(32'h0000_0004, "R5 rx exit status");
    chk("R7 exit irq cleared", {31'd0, exit_irq}, 32'h0);
    @(negedge clk); ext = 1'b0;
    idle(4);
    rd_exp(32'h0000_0000, "R5 idle after exit");

    // RX only, then TX entry raced against a read
    @(negedge clk); pat = 1'b1;
    idle(5);
    chk("R9 gate low with rx only", {31'd0, gate_ok}, 32'h0);
    rd_exp(32'h0000_0102, "R4 rx re-entry");
    wr_rd(32'h0001_0000, 32'h0000_0100, "R7 read returns pre-event word");
    chk("R8 irq kept by event during read", {31'd0, irq}, 32'h1);
    rd_exp(32'h0001_0301, "R8 event wins over read clear");
    chk("R9 gate high again", {31'd0, gate_ok}, 32'h1);

    idle(2);
    summary();
  end
endmodule